// File: doc/BRIEF.md
# Indexed Word Table Reader

This block fetches constants from a program memory that is sixteen bits wide. Two byte-wide index registers form the address of the table entry. The upper index gives the high address byte and the lower index gives the low address byte. A lookup command sends that address to a synchronous memory and splits the returned word across two destinations. The low byte goes into the accumulator and the high byte goes into a separate table-high register.

Software steps through a table by incrementing the lower index, or by adding the accumulator to it. Neither operation carries into the upper index. Each one reports its overflow in a carry flag, so a routine can decide when to bump the upper index itself.

Commands arrive one per cycle on a small opcode bus. A lookup keeps the block busy for two cycles, and every command that arrives in that window is dropped. The memory has 8K words, so only the low thirteen address bits reach it.

Top module: `word_table_reader`

## Requirements
- R1: A lookup accepted at a clock edge drives `mem_rd` high for exactly the following cycle. During that cycle `mem_addr` holds `{idx_hi, idx_lo}` as sampled at the accepting edge.
- R2: Two edges after the accepting edge, `acc` takes bits 7:0 of the fetched word and `tbl_hi` takes bits 15:8. A fetched word of 0x5105 gives `acc` = 0x05 and `tbl_hi` = 0x51.
- R3: Address bits at and above `ADDR_W` (default 13) do not reach the memory. With `idx_hi` = 0xE1 and `idx_lo` = 0x23, the word at address 0x0123 is read.
- R4: The load opcodes write `op_data` into a register. Opcode 1 writes the upper index, opcode 2 writes the lower index and opcode 3 writes the accumulator. Opcodes 0 and 7 change nothing.
- R5: Opcode 4 increments the lower index modulo 256. From 0xFF it wraps to 0x00 and sets `carry`, and `idx_hi` stays the same. From any other value it clears `carry`.
- R6: Opcode 5 sets the lower index to (`idx_lo` + `acc`) modulo 256. It sets `carry` exactly when the true sum exceeds 0xFF, and it leaves `idx_hi` unchanged.
- R7: Opcode 6 starts a lookup. `busy` is high for the two cycles after the accepting edge and low again once the result is loaded.
- R8: Every command presented while `busy` is high is ignored. Index registers, accumulator and carry keep their values, and no second memory read starts.
- R9: After a clock edge with `rst_n` low, all registers read zero and `busy` and `mem_rd` are low.
- R10: `carry` changes only on opcodes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | A command is presented this cycle |
| op_code | input | 3 | Command: 0 none, 1 load upper index, 2 load lower index, 3 load accumulator, 4 increment lower index, 5 add accumulator to lower index, 6 lookup, 7 none |
| op_data | input | 8 | Operand for the load commands |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 13 | Word address presented to the memory |
| mem_rdata | input | 16 | Word returned by the memory one cycle after `mem_rd` |
| busy | output | 1 | A lookup is in progress, so commands are dropped |
| acc | output | 8 | Accumulator |
| tbl_hi | output | 8 | Upper byte of the last fetched word |
| idx_hi | output | 8 | Upper index register |
| idx_lo | output | 8 | Lower index register |
| carry | output | 1 | Overflow of the last increment or add on the lower index |

## Verification
The assertions assume that `op_code` is never unknown while `op_valid` is high. They also assume the memory answers with registered data exactly one cycle after each `mem_rd` pulse. The bench models a memory that returns a computed pattern on that fixed latency. It drives inputs only on the falling edge with defined values, so both assumptions hold throughout. Random command streams push many lookups into the busy window, which exercises the drop rule against the reference model.

// File: rtl/wtr_pkg.sv
// Shared types for the indexed word table reader.
// Assumes: opcode values are fixed by the command bus and shared with software.
package wtr_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_SET_HI  = 3'd1,
        OP_SET_LO  = 3'd2,
        OP_SET_ACC = 3'd3,
        OP_INC_LO  = 3'd4,
        OP_ADD_LO  = 3'd5,
        OP_FETCH   = 3'd6,
        OP_SPARE   = 3'd7
    } wtr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_TAKE = 2'd2
    } wtr_state_e;

    typedef struct packed {
        logic set_hi;
        logic set_lo;
        logic set_acc;
        logic inc_lo;
        logic add_lo;
        logic fetch;
    } wtr_strobe_t;

endpackage

// File: rtl/wtr_cmd_decode.sv
// Command decoder: turns an accepted command into one action strobe.
// Assumes: op_code is known while op_valid is high; while busy every command is dropped.
module wtr_cmd_decode
    import wtr_pkg::*;
(
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic        busy,
    output wtr_strobe_t stb
);

    // Decode one strobe when the block is free to accept a command.
    always_comb begin
        stb = '0;
        if (op_valid && !busy) begin
            case (wtr_op_e'(op_code))
                OP_SET_HI:  stb.set_hi  = 1'b1;
                OP_SET_LO:  stb.set_lo  = 1'b1;
                OP_SET_ACC: stb.set_acc = 1'b1;
                OP_INC_LO:  stb.inc_lo  = 1'b1;
                OP_ADD_LO:  stb.add_lo  = 1'b1;
                OP_FETCH:   stb.fetch   = 1'b1;
                default:    stb = '0;
            endcase
        end
    end

endmodule

// File: rtl/wtr_index_unit.sv
// Index register pair with a byte-wide increment and add on the lower index.
// Arithmetic never carries into the upper index; the overflow goes to a carry flag.
// Assumes: at most one strobe is active per cycle.
module wtr_index_unit
    import wtr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wtr_strobe_t      stb,
    input  logic [IDX_W-1:0] op_data,
    input  logic [IDX_W-1:0] acc,
    output logic [IDX_W-1:0] idx_hi,
    output logic [IDX_W-1:0] idx_lo,
    output logic             carry
);

    localparam int SUM_W = IDX_W + 1;

    logic [SUM_W-1:0] inc_sum;
    logic [SUM_W-1:0] add_sum;

    // Widened sums so that the top bit is the overflow out of the lower index.
    always_comb begin
        inc_sum = {1'b0, idx_lo} + {{IDX_W{1'b0}}, 1'b1};
        add_sum = {1'b0, idx_lo} + {1'b0, acc};
    end

    // Upper index register: written only by its load command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_hi <= '0;
        else if (stb.set_hi)
            idx_hi <= op_data;
    end

    // Lower index register and carry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_lo <= '0;
            carry  <= 1'b0;
        end else if (stb.set_lo) begin
            idx_lo <= op_data;
        end else if (stb.inc_lo) begin
            idx_lo <= inc_sum[IDX_W-1:0];
            carry  <= inc_sum[IDX_W];
        end else if (stb.add_lo) begin
            idx_lo <= add_sum[IDX_W-1:0];
            carry  <= add_sum[IDX_W];
        end
    end

endmodule

// File: rtl/wtr_fetch_seq.sv
// Lookup sequencer: registers the word address, pulses the read strobe and
// marks the capture cycle two edges after the command.
// Assumes: memory data is valid one cycle after the read strobe.
module wtr_fetch_seq
    import wtr_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic [IDX_W-1:0]  idx_hi,
    input  logic [IDX_W-1:0]  idx_lo,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              take
);

    localparam int FULL_W = 2 * IDX_W;

    wtr_state_e        state_q;
    wtr_state_e        state_d;
    logic [FULL_W-1:0] full_addr;
    logic [ADDR_W-1:0] addr_next;

    assign full_addr = {idx_hi, idx_lo};

    // Fit the index pair to the memory: drop high bits or pad with zeros.
    generate
        if (ADDR_W <= FULL_W) begin : g_trunc
            assign addr_next = full_addr[ADDR_W-1:0];
        end else begin : g_pad
            assign addr_next = {{(ADDR_W-FULL_W){1'b0}}, full_addr};
        end
    endgenerate

    // Next-state logic of the three-step lookup sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (fetch) state_d = ST_WAIT;
            ST_WAIT: state_d = ST_TAKE;
            ST_TAKE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Address and one-cycle read strobe toward the memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd   <= 1'b0;
            mem_addr <= '0;
        end else begin
            mem_rd <= fetch && (state_q == ST_IDLE);
            if (fetch && (state_q == ST_IDLE))
                mem_addr <= addr_next;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign take = (state_q == ST_TAKE);

endmodule

// File: rtl/wtr_result_regs.sv
// Destination registers: the accumulator and the table-high byte.
// A capture splits the fetched word; the accumulator can also be loaded directly.
// Assumes: take and set_acc are never active together.
module wtr_result_regs
    import wtr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wtr_strobe_t        stb,
    input  logic               take,
    input  logic [IDX_W-1:0]   op_data,
    input  logic [2*IDX_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]   acc,
    output logic [IDX_W-1:0]   tbl_hi
);

    localparam int WORD_W = 2 * IDX_W;

    logic [IDX_W-1:0] word_lo;
    logic [IDX_W-1:0] word_hi;

    assign word_lo = mem_rdata[IDX_W-1:0];
    assign word_hi = mem_rdata[WORD_W-1:IDX_W];

    // Accumulator: loaded from the command bus or from the low byte of the word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (take)
            acc <= word_lo;
        else if (stb.set_acc)
            acc <= op_data;
    end

    // Table-high register: loaded only from the high byte of the word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_hi <= '0;
        else if (take)
            tbl_hi <= word_hi;
    end

endmodule

// File: rtl/word_table_reader.sv
// Indexed word table reader, top level.
// Forms a word address from two index bytes, reads a synchronous memory and
// splits the word into the accumulator and the table-high register.
// Assumes: the memory returns registered data one cycle after mem_rd.
module word_table_reader
    import wtr_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [2:0]           op_code,
    input  logic [IDX_W-1:0]     op_data,
    output logic                 mem_rd,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [2*IDX_W-1:0]   mem_rdata,
    output logic                 busy,
    output logic [IDX_W-1:0]     acc,
    output logic [IDX_W-1:0]     tbl_hi,
    output logic [IDX_W-1:0]     idx_hi,
    output logic [IDX_W-1:0]     idx_lo,
    output logic                 carry
);

    wtr_strobe_t stb;
    logic        take;

    wtr_cmd_decode u_decode (
        .op_valid (op_valid),
        .op_code  (op_code),
        .busy     (busy),
        .stb      (stb)
    );

    wtr_index_unit #(.IDX_W(IDX_W)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .op_data (op_data),
        .acc     (acc),
        .idx_hi  (idx_hi),
        .idx_lo  (idx_lo),
        .carry   (carry)
    );

    wtr_fetch_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch    (stb.fetch),
        .idx_hi   (idx_hi),
        .idx_lo   (idx_lo),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .busy     (busy),
        .take     (take)
    );

    wtr_result_regs #(.IDX_W(IDX_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb),
        .take      (take),
        .op_data   (op_data),
        .mem_rdata (mem_rdata),
        .acc       (acc),
        .tbl_hi    (tbl_hi)
    );

endmodule

// File: rtl/wtr_checker.sv
// Protocol and behaviour checks for word_table_reader, bound to every instance.
// Assumes: op_code is known whenever op_valid is high.
module wtr_checker #(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic              busy,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [IDX_W-1:0]  idx_hi,
    input logic [IDX_W-1:0]  idx_lo,
    input logic              carry
);

    localparam int FULL_W = 2 * IDX_W;

    logic [FULL_W-1:0] pair;
    logic [ADDR_W-1:0] pair_fit;
    logic              free_cmd;

    assign pair     = {idx_hi, idx_lo};
    assign pair_fit = ADDR_W'(pair);
    assign free_cmd = op_valid && !busy;

    // R1 / R3: the memory sees the truncated index pair from the accepting edge.
    assert_fetch_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cmd && op_code == 3'd6) |=> (mem_rd && mem_addr == $past(pair_fit)));

    // R1: the read strobe lasts a single cycle.
    assert_rd_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R5: increment from all-ones wraps, raises carry, keeps the upper index.
    assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cmd && op_code == 3'd4 && idx_lo == '1)
        |=> (idx_lo == '0 && carry && idx_hi == $past(idx_hi)));

    // R6: add never touches the upper index.
    assert_add_keep_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cmd && op_code == 3'd5) |=> (idx_hi == $past(idx_hi)));

    // R7: an accepted lookup raises busy on the next cycle.
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cmd && op_code == 3'd6) |=> busy);

    // R7: busy stays high for a second cycle after it rises.
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R7: busy drops after its second cycle.
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    // R8: nothing in the index path moves while busy.
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(idx_hi) && $stable(idx_lo) && $stable(carry)));

    // R8: no second read is started inside a lookup.
    assert_no_rd_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !mem_rd);

endmodule

bind word_table_reader wtr_checker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .busy     (busy),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .idx_hi   (idx_hi),
    .idx_lo   (idx_lo),
    .carry    (carry)
);

// File: tb/word_table_reader_tb_top.sv
// Bench for word_table_reader: a behavioural reference model updated on each
// rising edge and compared with the design on each falling edge.
module word_table_reader_tb_top;

    localparam int IDX_W  = 8;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [2:0]        op_code = 3'd0;
    logic [7:0]        op_data = 8'd0;
    logic              mem_rd;
    logic [12:0]       mem_addr;
    logic [15:0]       mem_rdata = 16'd0;
    logic              busy;
    logic [7:0]        acc;
    logic [7:0]        tbl_hi;
    logic [7:0]        idx_hi;
    logic [7:0]        idx_lo;
    logic              carry;

    int checks = 0;
    int errors = 0;

    // reference model state
    int  m_hi = 0, m_lo = 0, m_acc = 0, m_res = 0, m_c = 0, m_pend = 0, m_addr = 0;
    bit  m_rd = 0;
    bit  started = 0;

    always #2 clk = ~clk;

    word_table_reader #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_data   (op_data),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .acc       (acc),
        .tbl_hi    (tbl_hi),
        .idx_hi    (idx_hi),
        .idx_lo    (idx_lo),
        .carry     (carry)
    );

    // Computed table contents; address 0x0123 holds 0x5105.
    function automatic int table_word(int a);
        if (a == 'h0123) return 'h5105;
        return ((a * 'h9E37) ^ (a << 5) ^ 'hA5C3) & 'hFFFF;
    endfunction

    // Memory model: registered read, one cycle latency.
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= 16'(table_word(int'(mem_addr)));
    end

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_acc = 0; m_res = 0; m_c = 0; m_pend = 0; m_rd = 0; m_addr = 0;
        end else begin
            m_rd = 0;
            if (m_pend == 2) begin
                m_pend = 1;
            end else if (m_pend == 1) begin
                m_acc  = table_word(m_addr) & 'hFF;
                m_res  = (table_word(m_addr) >> 8) & 'hFF;
                m_pend = 0;
            end else if (op_valid) begin
                case (op_code)
                    3'd1: m_hi  = int'(op_data);
                    3'd2: m_lo  = int'(op_data);
                    3'd3: m_acc = int'(op_data);
                    3'd4: begin m_c = (m_lo == 255); m_lo = (m_lo + 1) & 'hFF; end
                    3'd5: begin m_c = ((m_lo + m_acc) > 255); m_lo = (m_lo + m_acc) & 'hFF; end
                    3'd6: begin m_addr = ((m_hi << 8) | m_lo) & 'h1FFF; m_pend = 2; m_rd = 1; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R2 acc", int'(acc), m_acc);
            chk("R2 tbl_hi", int'(tbl_hi), m_res);
            chk("R4 idx_hi", int'(idx_hi), m_hi);
            chk("R4 idx_lo", int'(idx_lo), m_lo);
            chk("R5 carry", int'(carry), m_c);
            chk("R7 busy", int'(busy), int'(m_pend != 0));
            chk("R1 mem_rd", int'(mem_rd), int'(m_rd));
            if (m_rd) chk("R1 mem_addr", int'(mem_addr), m_addr);
        end
    end

    task automatic step(input int op, input int data);
        @(negedge clk);
        op_valid = (op != 0);
        op_code  = 3'(op);
        op_data  = 8'(data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 acc", int'(acc), 0);
        chk("R9 idx_hi", int'(idx_hi), 0);
        chk("R9 busy", int'(busy), 0);
        chk("R9 mem_rd", int'(mem_rd), 0);
        rst_n = 1'b1;

        // R3 and R2: high address bits dropped, word 0x5105 split
        step(1, 'hE1); step(2, 'h23); step(6, 0);
        idle(1);
        chk("R7 busy mid lookup", int'(busy), 1);
        idle(2);
        chk("R3 acc from 0x0123", int'(acc), 'h05);
        chk("R2 tbl_hi from 0x5105", int'(tbl_hi), 'h51);
        chk("R7 busy released", int'(busy), 0);

        // R8: commands during busy are dropped
        step(1, 'h10); step(2, 'h20); step(6, 0);
        step(1, 'h77); step(6, 0);
        idle(2);
        chk("R8 idx_hi kept", int'(idx_hi), 'h10);
        chk("R8 no restart", int'(busy), 0);

        // R5: wrap on increment
        step(1, 'h3C); step(2, 'hFF); step(4, 0); idle(1);
        chk("R5 idx_lo wrapped", int'(idx_lo), 0);
        chk("R5 carry set", int'(carry), 1);
        chk("R5 idx_hi kept", int'(idx_hi), 'h3C);

        // R10: loads leave carry alone
        step(1, 'h44); step(3, 'h90); idle(1);
        chk("R10 carry kept", int'(carry), 1);

        // R6: add with and without overflow
        step(2, 'h80); step(5, 0); idle(1);
        chk("R6 idx_lo sum", int'(idx_lo), 'h10);
        chk("R6 carry set", int'(carry), 1);
        chk("R6 idx_hi kept", int'(idx_hi), 'h44);
        step(3, 'h01); step(5, 0); idle(1);
        chk("R6 idx_lo sum2", int'(idx_lo), 'h11);
        chk("R6 carry clear", int'(carry), 0);

        // R4: spare opcode changes nothing
        step(7, 'hAA); idle(1);
        chk("R4 spare opcode", int'(idx_lo), 'h11);

        // Random command stream against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r > 7) r = 6;
            step(r, int'($urandom_range(0, 255)));
        end
        idle(4);
        finish_run();
    end

endmodule